// File: doc/BRIEF.md
# Operand Forwarding Control (Last Result and Last Load)

This block decides, for each instruction entering the register-read stage of a pipelined 32-bit processor with sixteen architectural registers, where each of its two source operands comes from. There are two bypass sources besides the register file. The first is a one-shot copy of the most recent ALU result, meant for the instruction that directly follows its producer. The second is a copy of the most recently returned load datum, which stays usable for any number of later instructions until something overwrites that register.

Because loads may still be in flight, the loaded-value path is guarded by a counter of outstanding loads rather than by matching tags on returning data. A load issue raises the count and a load return lowers it. An instruction that needs the loaded value is held, with a stall output, until the count is zero. Only results of unconditionally executed producers are ever forwarded. Each path can be switched off on its own. When no path applies, the select points at the register file, where the normal register-lock read takes over.

The block drives the operand multiplexer selects, the stall, and the two held bypass values. The register file and the multiplexers themselves are outside it.

Top module: `operand_fwd_ctrl`

## Requirements
- R1: After reset both selects read 00, stall is low, and both held bypass values read zero. Select encoding: 00 register file, 01 last ALU result, 10 last loaded value.
- R2: When an accepted instruction has a used source whose number equals the held ALU-result destination, and that result is valid and the result path is enabled, the operand select is 01.
- R3: A result event replaces the held result data and destination. That result is valid only for the first instruction accepted in a later cycle. Once that instruction has been accepted the result path no longer matches until the next result event.
- R4: A result event whose producer is not unconditionally executed (`res_always_i` low) leaves the result path invalid, so a matching operand selects 00.
- R5: A load return overwrites the held loaded value and its destination. The value then matches (select 10) for any number of later instructions while the outstanding count is zero.
- R6: A result event writing the loaded value's destination register invalidates the loaded-value path. A load return in the same cycle takes precedence and leaves it valid.
- R7: A load issue adds one and a load return subtracts one from the outstanding count. Both in one cycle leave it unchanged. A return at zero does not decrement, and an issue at the maximum (2^CNT_W-1) does not increment unless a return occurs in the same cycle.
- R8: An operand that selects the loaded-value path while the outstanding count is nonzero raises `stall_o`, and the select still reads 10. A stalled instruction is not accepted.
- R9: When both paths match the same operand, the last-result path (01) wins.
- R10: With `lrr_en_i` low the result path never selects. With `llv_en_i` low the loaded-value path never selects and never stalls. The paths are otherwise independent.
- R11: With `iss_valid_i` low, both selects read 00 and stall is low. An operand whose use flag is low selects 00 and cannot stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lrr_en_i | input | 1 | Enable for the last-result path |
| llv_en_i | input | 1 | Enable for the loaded-value path |
| iss_valid_i | input | 1 | An instruction is presented for operand selection |
| src_a_i | input | 4 | First source register number |
| src_a_use_i | input | 1 | First source is read |
| src_b_i | input | 4 | Second source register number |
| src_b_use_i | input | 1 | Second source is read |
| res_valid_i | input | 1 | ALU result event this cycle |
| res_always_i | input | 1 | Producer of that result executes unconditionally |
| res_dst_i | input | 4 | Destination register of that result |
| res_data_i | input | 32 | Result value |
| ld_issue_i | input | 1 | A load is sent to memory |
| ld_ret_i | input | 1 | A load datum returns |
| ld_ret_dst_i | input | 4 | Destination register of the returning load |
| ld_ret_data_i | input | 32 | Returning load datum |
| sel_a_o | output | 2 | Select for the first operand |
| sel_b_o | output | 2 | Select for the second operand |
| stall_o | output | 1 | Hold the presented instruction |
| lrr_data_o | output | 32 | Held last ALU result |
| llv_data_o | output | 32 | Held last loaded value |

## Verification
Directed sequences exercise each of the following in turn: result followed at once by a consumer, a second consumer of the same result, a conditional producer, a load value reused over several instructions, an ALU write that kills the load value, and simultaneous return and write to one register. Separate sequences cover loads left outstanding while a consumer waits, returns at zero, more issues than the counter holds, both paths matching one operand, and each enable alone. These tell apart one-shot from persistent validity, the priority order, and count-gated from tag-gated load forwarding. A long random phase over a narrow register range then mixes all events in every cycle. There, a behavioural model checks selects, stall and held values each clock.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  typedef enum logic [1:0] {
    SEL_RF  = 2'b00,
    SEL_LRR = 2'b01,
    SEL_LLV = 2'b10
  } opsel_e;
endpackage

// File: rtl/fwd_rst_sync.sv
module fwd_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/fwd_lrr_track.sv
module fwd_lrr_track #(
  parameter int XLEN = 32,
  parameter int RW   = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            res_valid,
  input  logic            res_always,
  input  logic [RW-1:0]   res_dst,
  input  logic [XLEN-1:0] res_data,
  input  logic            accept,
  output logic            valid,
  output logic [RW-1:0]   tag,
  output logic [XLEN-1:0] data
);
  logic valid_n;

  // One-shot validity: consumed by the next accepted instruction,
  // refreshed by every result event (which wins over consumption).
  always_comb begin
    valid_n = valid;
    if (accept)    valid_n = 1'b0;
    if (res_valid) valid_n = res_always;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      tag   <= '0;
      data  <= '0;
    end else begin
      valid <= valid_n;
      if (res_valid) begin
        tag  <= res_dst;
        data <= res_data;
      end
    end
  end
endmodule

// File: rtl/fwd_llv_track.sv
module fwd_llv_track #(
  parameter int XLEN  = 32,
  parameter int RW    = 4,
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_issue,
  input  logic             ld_ret,
  input  logic [RW-1:0]    ret_dst,
  input  logic [XLEN-1:0]  ret_data,
  input  logic             res_valid,
  input  logic [RW-1:0]    res_dst,
  output logic             valid,
  output logic [RW-1:0]    tag,
  output logic [XLEN-1:0]  data,
  output logic [CNT_W-1:0] cnt,
  output logic             cnt_zero
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic             valid_n;
  logic [CNT_W-1:0] cnt_n;
  logic             dec, inc;

  assign cnt_zero = (cnt == '0);
  assign dec      = ld_ret & ~cnt_zero;
  assign inc      = ld_issue & ((cnt != CNT_MAX) | dec);

  always_comb begin
    unique case ({inc, dec})
      2'b10:   cnt_n = cnt + 1'b1;
      2'b01:   cnt_n = cnt - 1'b1;
      default: cnt_n = cnt;
    endcase
  end

  always_comb begin
    valid_n = valid;
    if (ld_ret)                              valid_n = 1'b1;
    else if (res_valid && (res_dst == tag))  valid_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      tag   <= '0;
      data  <= '0;
      cnt   <= '0;
    end else begin
      valid <= valid_n;
      cnt   <= cnt_n;
      if (ld_ret) begin
        tag  <= ret_dst;
        data <= ret_data;
      end
    end
  end
endmodule

// File: rtl/fwd_src_select.sv
module fwd_src_select
  import fwd_pkg::*;
#(
  parameter int RW = 4
) (
  input  logic          use_i,
  input  logic [RW-1:0] src_i,
  input  logic          lrr_en,
  input  logic          lrr_valid,
  input  logic [RW-1:0] lrr_tag,
  input  logic          llv_en,
  input  logic          llv_valid,
  input  logic [RW-1:0] llv_tag,
  input  logic          cnt_zero,
  output opsel_e        sel,
  output logic          wait_o
);
  logic hit_lrr, hit_llv;

  assign hit_lrr = use_i & lrr_en & lrr_valid & (src_i == lrr_tag);
  assign hit_llv = use_i & llv_en & llv_valid & (src_i == llv_tag);

  always_comb begin
    sel    = SEL_RF;
    wait_o = 1'b0;
    if (hit_lrr) begin
      sel = SEL_LRR;
    end else if (hit_llv) begin
      sel    = SEL_LLV;
      wait_o = ~cnt_zero;
    end
  end
endmodule

// File: rtl/operand_fwd_ctrl.sv
module operand_fwd_ctrl
  import fwd_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int NREG  = 16,
  parameter int CNT_W = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    lrr_en_i,
  input  logic                    llv_en_i,
  input  logic                    iss_valid_i,
  input  logic [$clog2(NREG)-1:0] src_a_i,
  input  logic                    src_a_use_i,
  input  logic [$clog2(NREG)-1:0] src_b_i,
  input  logic                    src_b_use_i,
  input  logic                    res_valid_i,
  input  logic                    res_always_i,
  input  logic [$clog2(NREG)-1:0] res_dst_i,
  input  logic [XLEN-1:0]         res_data_i,
  input  logic                    ld_issue_i,
  input  logic                    ld_ret_i,
  input  logic [$clog2(NREG)-1:0] ld_ret_dst_i,
  input  logic [XLEN-1:0]         ld_ret_data_i,
  output logic [1:0]              sel_a_o,
  output logic [1:0]              sel_b_o,
  output logic                    stall_o,
  output logic [XLEN-1:0]         lrr_data_o,
  output logic [XLEN-1:0]         llv_data_o
);
  localparam int RW   = $clog2(NREG);
  localparam int NOPS = 2;

  logic             rst_n_int;
  logic             accept;
  logic             lrr_valid, llv_valid, cnt_zero;
  logic [RW-1:0]    lrr_tag, llv_tag;
  logic [CNT_W-1:0] tok_cnt;

  logic [RW-1:0]    src_v  [NOPS];
  logic             use_v  [NOPS];
  opsel_e           sel_v  [NOPS];
  logic [NOPS-1:0]  wait_v;

  assign src_v[0] = src_a_i;
  assign src_v[1] = src_b_i;
  assign use_v[0] = src_a_use_i;
  assign use_v[1] = src_b_use_i;

  fwd_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  fwd_lrr_track #(.XLEN(XLEN), .RW(RW)) u_lrr (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .res_valid  (res_valid_i),
    .res_always (res_always_i),
    .res_dst    (res_dst_i),
    .res_data   (res_data_i),
    .accept     (accept),
    .valid      (lrr_valid),
    .tag        (lrr_tag),
    .data       (lrr_data_o)
  );

  fwd_llv_track #(.XLEN(XLEN), .RW(RW), .CNT_W(CNT_W)) u_llv (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .ld_issue  (ld_issue_i),
    .ld_ret    (ld_ret_i),
    .ret_dst   (ld_ret_dst_i),
    .ret_data  (ld_ret_data_i),
    .res_valid (res_valid_i),
    .res_dst   (res_dst_i),
    .valid     (llv_valid),
    .tag       (llv_tag),
    .data      (llv_data_o),
    .cnt       (tok_cnt),
    .cnt_zero  (cnt_zero)
  );

  for (genvar g = 0; g < NOPS; g++) begin : g_op
    fwd_src_select #(.RW(RW)) u_sel (
      .use_i     (use_v[g]),
      .src_i     (src_v[g]),
      .lrr_en    (lrr_en_i),
      .lrr_valid (lrr_valid),
      .lrr_tag   (lrr_tag),
      .llv_en    (llv_en_i),
      .llv_valid (llv_valid),
      .llv_tag   (llv_tag),
      .cnt_zero  (cnt_zero),
      .sel       (sel_v[g]),
      .wait_o    (wait_v[g])
    );
  end

  assign stall_o = iss_valid_i & (|wait_v);
  assign accept  = iss_valid_i & ~stall_o;
  assign sel_a_o = iss_valid_i ? sel_v[0] : SEL_RF;
  assign sel_b_o = iss_valid_i ? sel_v[1] : SEL_RF;
endmodule

// File: rtl/fwd_ctrl_chk.sv
module fwd_ctrl_chk #(
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lrr_en_i,
  input logic             llv_en_i,
  input logic             iss_valid_i,
  input logic             res_valid_i,
  input logic             ld_issue_i,
  input logic             ld_ret_i,
  input logic [1:0]       sel_a_o,
  input logic [1:0]       sel_b_o,
  input logic             stall_o,
  input logic [CNT_W-1:0] tok_cnt
);
  // R10
  lrr_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_a_o == 2'b01 || sel_b_o == 2'b01) |-> lrr_en_i);

  // R10
  llv_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_a_o == 2'b10 || sel_b_o == 2'b10) |-> llv_en_i);

  // R8
  stall_only_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall_o |-> (tok_cnt != '0 && (sel_a_o == 2'b10 || sel_b_o == 2'b10)));

  // R7
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_ret_i && !ld_issue_i && tok_cnt == '0) |=> (tok_cnt == '0));

  // R7
  net_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_ret_i && ld_issue_i && tok_cnt != '0) |=> $stable(tok_cnt));

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !iss_valid_i |-> (sel_a_o == 2'b00 && sel_b_o == 2'b00 && !stall_o));

  // R3
  lrr_one_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid_i && !stall_o && !res_valid_i) |=> (sel_a_o != 2'b01 && sel_b_o != 2'b01));
endmodule

bind operand_fwd_ctrl fwd_ctrl_chk #(.CNT_W(CNT_W)) chk_i (.*);

// File: tb/operand_fwd_ctrl_tb_top.sv
`timescale 1ns/1ps
module operand_fwd_ctrl_tb_top;
  localparam int CNT_W   = 3;
  localparam int CNT_MAX = (1 << CNT_W) - 1;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        lrr_en, llv_en, iss_valid;
  logic [3:0]  src_a, src_b, res_dst, ret_dst;
  logic        use_a, use_b, res_valid, res_always, ld_issue, ld_ret;
  logic [31:0] res_data, ret_data;
  logic [1:0]  sel_a, sel_b;
  logic        stall;
  logic [31:0] lrr_data, llv_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // behavioural reference state
  bit m_lrr_v, m_llv_v;
  int m_lrr_t, m_llv_t, m_cnt;
  logic [31:0] m_lrr_d, m_llv_d;

  always #2.5 clk = ~clk;

  operand_fwd_ctrl #(.CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .lrr_en_i(lrr_en), .llv_en_i(llv_en),
    .iss_valid_i(iss_valid), .src_a_i(src_a), .src_a_use_i(use_a),
    .src_b_i(src_b), .src_b_use_i(use_b), .res_valid_i(res_valid),
    .res_always_i(res_always), .res_dst_i(res_dst), .res_data_i(res_data),
    .ld_issue_i(ld_issue), .ld_ret_i(ld_ret), .ld_ret_dst_i(ret_dst),
    .ld_ret_data_i(ret_data), .sel_a_o(sel_a), .sel_b_o(sel_b),
    .stall_o(stall), .lrr_data_o(lrr_data), .llv_data_o(llv_data)
  );

  task automatic model_reset();
    m_lrr_v = 0; m_llv_v = 0; m_lrr_t = 0; m_llv_t = 0; m_cnt = 0;
    m_lrr_d = '0; m_llv_d = '0;
  endtask

  function automatic int exp_sel(bit u, int src, output bit w);
    w = 0;
    if (!iss_valid || !u) return 0;
    if (lrr_en && m_lrr_v && src == m_lrr_t) return 1;
    if (llv_en && m_llv_v && src == m_llv_t) begin
      w = (m_cnt != 0);
      return 2;
    end
    return 0;
  endfunction

  task automatic cmp(string tag, string what, longint got, longint exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h at %0t", tag, what, got, exp, $time);
    end
  endtask

  task automatic idle_inputs();
    iss_valid = 0; use_a = 0; use_b = 0; src_a = 0; src_b = 0;
    res_valid = 0; res_always = 0; res_dst = 0; res_data = 0;
    ld_issue = 0; ld_ret = 0; ret_dst = 0; ret_data = 0;
  endtask

  // Inputs are already set; check at negedge, advance model at posedge.
  task automatic cyc(string tag);
    bit wa, wb, st, acc, dec, inc;
    int ea, eb;
    @(negedge clk);
    ea = exp_sel(use_a, int'(src_a), wa);
    eb = exp_sel(use_b, int'(src_b), wb);
    st = wa | wb;
    cmp(tag, "sel_a", sel_a, ea);
    cmp(tag, "sel_b", sel_b, eb);
    cmp(tag, "stall", stall, st);
    cmp(tag, "lrr_data", lrr_data, m_lrr_d);
    cmp(tag, "llv_data", llv_data, m_llv_d);
    @(posedge clk);
    acc = iss_valid && !st;
    if (acc) m_lrr_v = 0;
    if (res_valid) begin
      m_lrr_v = res_always; m_lrr_t = res_dst; m_lrr_d = res_data;
    end
    if (ld_ret) begin
      m_llv_v = 1; m_llv_t = ret_dst; m_llv_d = ret_data;
    end else if (res_valid && int'(res_dst) == m_llv_t) m_llv_v = 0;
    dec = ld_ret && m_cnt > 0;
    inc = ld_issue && (m_cnt < CNT_MAX || dec);
    m_cnt = m_cnt + int'(inc) - int'(dec);
    #1;
    idle_inputs();
  endtask

  task automatic issue(int a, bit ua, int b, bit ub);
    iss_valid = 1; src_a = a[3:0]; use_a = ua; src_b = b[3:0]; use_b = ub;
  endtask

  task automatic result(int d, bit alw, logic [31:0] v);
    res_valid = 1; res_dst = d[3:0]; res_always = alw; res_data = v;
  endtask

  task automatic ret(int d, logic [31:0] v);
    ld_ret = 1; ret_dst = d[3:0]; ret_data = v;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 0; lrr_en = 1; llv_en = 1;
    idle_inputs();
    model_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (4) cyc("R1");

    // R2: result then immediate consumer; other operand from file
    result(3, 1, 32'hA0A0_0001); cyc("R2");
    issue(3, 1, 5, 1); cyc("R2");
    // R3: second consumer sees nothing
    issue(3, 1, 3, 1); cyc("R3");
    // R3: result and consumer in same cycle, then next consumer
    result(6, 1, 32'h0000_0066); cyc("R3");
    issue(6, 1, 0, 0); result(6, 1, 32'h0000_0067); cyc("R3");
    issue(0, 0, 6, 1); cyc("R3");
    // R3: idle cycles do not consume
    result(2, 1, 32'h22); cyc("R3");
    cyc("R3"); cyc("R3");
    issue(2, 1, 2, 1); cyc("R3");
    // R4: conditional producer
    result(4, 0, 32'h44); cyc("R4");
    issue(4, 1, 4, 1); cyc("R4");

    // R5: load value reused
    ld_issue = 1; cyc("R5");
    ret(7, 32'h7777_0007); cyc("R5");
    for (int i = 0; i < 4; i++) begin issue(7, 1, 1, 1); cyc("R5"); end
    // R6: ALU writes same register
    result(7, 1, 32'h0700); cyc("R6");
    issue(7, 1, 0, 0); cyc("R6");
    issue(7, 1, 0, 0); cyc("R6");
    // R6: return and result to same register in one cycle
    ret(9, 32'h9999); result(9, 1, 32'h9000); cyc("R6");
    // R9: both match, last result wins
    issue(9, 1, 9, 1); cyc("R9");
    issue(9, 1, 9, 1); cyc("R6");

    // R8: outstanding loads stall
    ld_issue = 1; cyc("R8");
    ld_issue = 1; cyc("R8");
    issue(9, 1, 0, 0); cyc("R8");
    issue(9, 1, 0, 0); ret(9, 32'h9A); cyc("R8");
    issue(9, 1, 0, 0); cyc("R8");
    issue(9, 1, 0, 0); ret(10, 32'hAA); cyc("R8");
    issue(10, 1, 9, 1); cyc("R8");

    // R7: underflow, net zero, saturation
    ret(11, 32'hB1); cyc("R7");
    ld_issue = 1; cyc("R7");
    issue(0, 0, 11, 1); cyc("R7");
    ld_issue = 1; ret(11, 32'hB2); cyc("R7");
    issue(11, 1, 0, 0); cyc("R7");
    ret(11, 32'hB3); cyc("R7");
    issue(11, 1, 0, 0); cyc("R7");
    for (int i = 0; i < CNT_MAX + 2; i++) begin ld_issue = 1; cyc("R7"); end
    for (int i = 0; i < CNT_MAX - 1; i++) begin ret(12, 32'hC0 + i); cyc("R7"); end
    issue(12, 1, 0, 0); cyc("R7");
    ld_issue = 1; ret(12, 32'hCF); cyc("R7");
    issue(12, 1, 0, 0); cyc("R7");
    ret(12, 32'hD0); cyc("R7");
    issue(12, 1, 0, 0); cyc("R7");

    // R10: enables
    lrr_en = 0;
    result(12, 1, 32'hE1); cyc("R10");
    issue(12, 1, 12, 1); cyc("R10");
    lrr_en = 1; llv_en = 0;
    ld_issue = 1; cyc("R10");
    issue(12, 1, 12, 1); cyc("R10");
    ret(13, 32'hE2); cyc("R10");
    issue(13, 1, 13, 1); cyc("R10");
    llv_en = 1;
    issue(13, 1, 13, 1); cyc("R10");

    // R11: no issue / unused operands
    result(1, 1, 32'hF1); cyc("R11");
    iss_valid = 0; src_a = 1; use_a = 1; src_b = 13; use_b = 1; cyc("R11");
    issue(1, 0, 13, 0); cyc("R11");

    // random mix
    for (int i = 0; i < 3000; i++) begin
      lrr_en = ($urandom_range(0, 9) != 0);
      llv_en = ($urandom_range(0, 9) != 0);
      if ($urandom_range(0, 1)) issue($urandom_range(0, 3), $urandom_range(0, 1),
                                      $urandom_range(0, 3), $urandom_range(0, 1));
      if ($urandom_range(0, 2) == 0) result($urandom_range(0, 3), $urandom_range(0, 3) != 0, $urandom);
      ld_issue = ($urandom_range(0, 3) == 0);
      if ($urandom_range(0, 3) == 0) ret($urandom_range(0, 3), $urandom);
      cyc("R2");
    end

    done = 1;
    summary();
    $finish;
  end
endmodule